// File: doc/BRIEF.md
# Four-Phase to Two-Phase Receiver Port Controller

This block sits on the receiving end of a point-to-point link between two clock islands. From the far side it sees a level-signalled (4-phase) request and answers with a level-signalled acknowledge. Toward its own island it talks in transitions (2-phase): it toggles a local request to announce a word, and it expects a toggle of the local acknowledge once the island has taken the word. A handshake pair with the receiver's clock pauser sits between these two sides. The controller asks the pauser to freeze the island clock and waits for the pauser to confirm. Only then does it acknowledge the link and flip the local request. As a result, the request is already settled when the island clock runs again.

The controller is a Moore state machine clocked by a fast reference clock. All three asynchronous inputs pass through a parameterised flip-flop synchroniser. There are two idle states, one for each parity of the 2-phase pair: `IDLE_LO` when the local request is low and `IDLE_HI` when it is high. A transfer moves through `ARM` (pause requested), `GRANT` (link acknowledged), `HOLD` (local request toggled, clock held), `RELEASE` (pause dropped, waiting for consumption) and back to idle. The path is `IDLE_x -> ARM` when the request is seen, `ARM -> GRANT` on pause confirm, `GRANT -> HOLD` unconditionally, `HOLD -> RELEASE` when the link request falls, and `RELEASE -> IDLE_x` when the consumption toggle has arrived and the pauser has let go. If the link request is withdrawn while in `ARM`, the machine goes `ARM -> FAULT -> IDLE_x` and raises an error flag for one cycle.

Top module: `rxp_ctrl`

## Requirements
- R1: A high link request (`lnk_req`) seen in an idle state raises the pause request (`pz_req`). `lnk_ack` stays low until the pauser confirms.
- R2: The ordering is: pause confirm (`pz_ack` high), then `lnk_ack` rises, then `loc_req` toggles. `loc_req` never changes unless both `lnk_ack` and `pz_req` are high.
- R3: `pz_req` stays high for as long as `lnk_req` stays high after the grant. It falls only once `lnk_req` has fallen, while `lnk_ack` is still high.
- R4: `lnk_ack` falls only after `loc_ack` equals `loc_req` (the island's acknowledge toggle has arrived). Until then it stays high, however long that takes.
- R5: `lnk_ack` also stays high until the pauser has dropped `pz_ack`. It falls only with `pz_req` low.
- R6: Both parities are valid idle states. A transfer that starts with `loc_req` low ends with it high, and the next transfer returns it to low. Each transfer produces exactly one `loc_req` transition.
- R7: If `lnk_req` falls before `lnk_ack` has risen, `proto_err` is high for exactly one cycle and `pz_req` drops. `lnk_ack` and `loc_req` are untouched.
- R8: Reset (active-low `rst_n`) drives `lnk_ack`, `pz_req`, `loc_req` and `proto_err` low and selects the even idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast reference clock |
| rst_n | input | 1 | active-low asynchronous reset |
| lnk_req | input | 1 | 4-phase request from the sender port |
| lnk_ack | output | 1 | 4-phase acknowledge to the sender port |
| pz_req | output | 1 | pause request to the receiver clock pauser |
| pz_ack | input | 1 | pauser confirms the clock is frozen |
| loc_req | output | 1 | 2-phase request to the receiving island |
| loc_ack | input | 1 | 2-phase acknowledge from the island (data consumed) |
| proto_err | output | 1 | one-cycle flag: link request withdrawn early |

## Verification
Two situations cannot occur with a well-behaved sender and pauser. One is a link request withdrawn between the pause request and the pause confirm. The other is a consumption toggle that arrives while the pauser still holds its confirm. The bench models the sender, the pauser and the island as separate tasks, so it can hold `pz_ack` back or keep it asserted on purpose. It drops `lnk_req` inside the `ARM` window, and it toggles `loc_ack` before releasing `pz_ack`. A monitor counts `loc_req` transitions over a burst of paired transfers, which shows that every word is announced exactly once.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    typedef enum logic [2:0] {
        IDLE_LO = 3'd0,
        ARM     = 3'd1,
        GRANT   = 3'd2,
        HOLD    = 3'd3,
        RELEASE = 3'd4,
        IDLE_HI = 3'd5,
        FAULT   = 3'd6
    } rxp_state_t;
endpackage

// File: rtl/rxp_sync.sv
module rxp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxp_ctrl.sv
module rxp_ctrl
    import rxp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_req,
    output logic lnk_ack,
    output logic pz_req,
    input  logic pz_ack,
    output logic loc_req,
    input  logic loc_ack,
    output logic proto_err
);
    localparam int NIN = 3;

    logic [NIN-1:0] raw_in, syn_in;
    logic           ar_s, as_s, sa_s;
    rxp_state_t     state_q, state_d;
    logic           par_q, par_d;

    assign raw_in = {loc_ack, pz_ack, lnk_req};

    rxp_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign ar_s = syn_in[0];
    assign as_s = syn_in[1];
    assign sa_s = syn_in[2];

    // next-state and parity
    always_comb begin
        state_d = state_q;
        par_d   = par_q;
        unique case (state_q)
            IDLE_LO, IDLE_HI: if (ar_s) state_d = ARM;
            ARM: begin
                if (!ar_s)     state_d = FAULT;
                else if (as_s) state_d = GRANT;
            end
            GRANT: begin
                state_d = HOLD;
                par_d   = ~par_q;
            end
            HOLD: if (!ar_s) state_d = RELEASE;
            RELEASE: if ((sa_s == par_q) && !as_s)
                         state_d = par_q ? IDLE_HI : IDLE_LO;
            FAULT: state_d = par_q ? IDLE_HI : IDLE_LO;
            default: state_d = IDLE_LO;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE_LO;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            par_q   <= par_d;
        end
    end

    // Moore outputs
    always_comb begin
        lnk_ack   = 1'b0;
        pz_req    = 1'b0;
        proto_err = 1'b0;
        unique case (state_q)
            IDLE_LO, IDLE_HI: ;
            ARM:     pz_req = 1'b1;
            GRANT, HOLD: begin
                pz_req  = 1'b1;
                lnk_ack = 1'b1;
            end
            RELEASE: lnk_ack = 1'b1;
            FAULT:   proto_err = 1'b1;
            default: ;
        endcase
    end

    assign loc_req = par_q;
endmodule

// File: rtl/rxp_ctrl_chk.sv
module rxp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic lnk_ack,
    input logic pz_req,
    input logic loc_req,
    input logic proto_err
);
    assert_pause_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pz_req) |-> !lnk_ack);

    assert_ack_needs_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_ack) |-> pz_req);

    assert_toggle_when_paused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(loc_req) |-> (lnk_ack && pz_req));

    assert_drop_pause_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pz_req) |-> (lnk_ack || proto_err));

    assert_ack_after_unpause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lnk_ack) |-> !pz_req);

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!lnk_ack && !pz_req));
endmodule

bind rxp_ctrl rxp_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lnk_ack   (lnk_ack),
    .pz_req    (pz_req),
    .loc_req   (loc_req),
    .proto_err (proto_err)
);

// File: tb/sim_rxp_ctrl.sv
module sim_rxp_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lnk_req = 1'b0, pz_ack = 1'b0, loc_ack = 1'b0;
    logic lnk_ack, pz_req, loc_req, proto_err;

    int n_chk = 0;
    int n_bad = 0;
    int toggles = 0;
    int err_pulses = 0;
    bit ok;

    always #2.5 clk = ~clk;

    rxp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lnk_req(lnk_req), .lnk_ack(lnk_ack),
        .pz_req(pz_req), .pz_ack(pz_ack), .loc_req(loc_req),
        .loc_ack(loc_ack), .proto_err(proto_err)
    );

    // monitors
    logic prev_sr = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (loc_req != prev_sr)) toggles++;
        if (rst_n && proto_err) err_pulses++;
        prev_sr = loc_req;
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_rs(input logic v, output bit hit);
        hit = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pz_req == v) begin hit = 1; break; end
        end
    endtask

    task automatic wait_aa(input logic v, output bit hit);
        hit = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (lnk_ack == v) begin hit = 1; break; end
        end
    endtask

    task automatic wait_sr(input logic v, output bit hit);
        hit = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (loc_req == v) begin hit = 1; break; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!lnk_ack && !pz_req && !loc_req && !proto_err, "R8 reset outputs",
              {lnk_ack, pz_req, loc_req, proto_err}, 0);
    endtask

    // one full transfer with detailed ordering checks
    task automatic t_transfer(input bit hold_pause);
        logic sr0;
        sr0 = loc_req;
        lnk_req = 1'b1;
        wait_rs(1'b1, ok);
        check(ok, "R1 pause request follows link request", pz_req, 1);
        repeat (6) @(negedge clk);
        check(!lnk_ack && loc_req == sr0, "R1 no ack before pause confirm", lnk_ack, 0);
        pz_ack = 1'b1;
        wait_aa(1'b1, ok);
        check(ok && loc_req == sr0, "R2 ack rises before local toggle", loc_req, sr0);
        wait_sr(~sr0, ok);
        check(ok && lnk_ack && pz_req, "R2 local request toggles while paused", loc_req, ~sr0);
        repeat (10) @(negedge clk);
        check(pz_req, "R3 pause held while link request high", pz_req, 1);
        lnk_req = 1'b0;
        wait_rs(1'b0, ok);
        check(ok && lnk_ack, "R3 pause dropped after link request falls, ack high", lnk_ack, 1);
        repeat (8) @(negedge clk);
        check(lnk_ack, "R4 ack held until consumption toggle", lnk_ack, 1);
        if (hold_pause) begin
            loc_ack = loc_req;
            repeat (10) @(negedge clk);
            check(lnk_ack, "R5 ack held while pauser confirm high", lnk_ack, 1);
            pz_ack = 1'b0;
        end else begin
            pz_ack = 1'b0;
            repeat (6) @(negedge clk);
            check(lnk_ack, "R4 ack held without toggle after unpause", lnk_ack, 1);
            loc_ack = loc_req;
        end
        wait_aa(1'b0, ok);
        check(ok && !pz_req, "R4 ack falls after consumption", lnk_ack, 0);
        check(loc_req == ~sr0, "R6 idle parity after transfer", loc_req, ~sr0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_fault();
        logic sr0;
        int e0;
        sr0 = loc_req;
        e0 = err_pulses;
        lnk_req = 1'b1;
        wait_rs(1'b1, ok);
        lnk_req = 1'b0;
        wait_rs(1'b0, ok);
        check(ok, "R7 pause dropped on early withdrawal", pz_req, 0);
        repeat (6) @(negedge clk);
        check(err_pulses - e0 == 1, "R7 single error pulse", err_pulses - e0, 1);
        check(!lnk_ack && loc_req == sr0, "R7 ack and local request untouched", loc_req, sr0);
    endtask

    // sender/pauser/island all well behaved, several words
    task automatic t_burst(input int words);
        int t0;
        t0 = toggles;
        for (int w = 0; w < words; w++) begin
            lnk_req = 1'b1;
            wait_rs(1'b1, ok);
            repeat (w % 3) @(negedge clk);
            pz_ack = 1'b1;
            wait_aa(1'b1, ok);
            lnk_req = 1'b0;
            wait_rs(1'b0, ok);
            pz_ack = 1'b0;
            wait_sr(~loc_ack, ok);
            loc_ack = loc_req;
            wait_aa(1'b0, ok);
            repeat (3) @(negedge clk);
        end
        check(toggles - t0 == words, "R6 one local transition per word", toggles - t0, words);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_transfer(1'b0);   // from even idle
                t_transfer(1'b1);   // from odd idle
                t_fault();
                t_burst(7);
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule